// File: doc/BRIEF.md
# Integer Immediate and Register Execute Slice

This block takes one 32-bit fixed-length instruction word per cycle, qualified by a valid strobe, and decodes and executes it against a local 32-entry register file. The supported instructions are listed below.

- Register-immediate forms: add with a sign-extended immediate, add with the immediate moved to the upper half, and OR with a zero-extended immediate.
- Three-register forms: add, reverse subtract, AND, OR, XOR and NAND.
- Shifts: left, logical right and arithmetic right.

Each accepted instruction writes its result into the register file. The same result is presented on a registered writeback port one cycle later. An instruction that cannot be decoded raises an illegal flag for that cycle instead and changes no state.

The two immediate add forms treat a source A index of zero as the constant zero, not as register 0. As a result, the upper-half add followed by the OR-immediate loads any 32-bit constant in two instructions. Results are written at the same edge that updates the writeback port, so a following instruction can read them at once.

Top module: `int_exec_slice`

## Requirements
- R1: Instruction fields run from most to least significant as follows. Bits [31:26] hold the primary opcode, [25:21] the destination D, [20:16] source A, and [15:0] the immediate. Three-register forms put source B in [15:11] and an extended opcode in [10:1], and bit 0 is ignored. For an accepted instruction, `wb_en` is high in the cycle after `insn_valid`, with `wb_idx` equal to D and `wb_data` equal to the result.
- R2: Primary opcode 14 writes A + sign-extended immediate. When A is 0, the constant zero is used in place of register 0.
- R3: Primary opcode 15 writes A + (immediate << 16). When A is 0, the constant zero is used in place of register 0.
- R4: Primary opcode 24 writes A | zero-extended immediate. Here A = 0 reads register 0 normally.
- R5: Primary opcode 31 selects the three-register forms by extended opcode: add 266, AND 28, OR 444, XOR 316 and NAND 476. Each writes the named operation of register A and register B.
- R6: Primary opcode 31 with extended opcode 40 writes register B minus register A.
- R7: The shift amount is the low 6 bits of register B. Extended opcode 24 shifts A left and 536 shifts A right with zero fill. An amount of 32 or more gives 0.
- R8: Extended opcode 792 shifts A right with sign fill. An amount of 32 or more gives 32 copies of A's sign bit.
- R9: A valid word with any other primary opcode, or with opcode 31 and any other extended opcode, sets `illegal` for exactly the following cycle. It leaves `wb_en` low and leaves every register unchanged.
- R10: Reset clears `wb_en`, `illegal`, `wb_idx`, `wb_data` and all registers to zero. A cycle without `insn_valid` produces no writeback, no illegal flag and no register change.
- R11: A result written by one instruction is visible to the instruction in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| wb_en | output | 1 | Writeback performed, one cycle after the instruction |
| wb_idx | output | 5 | Destination register of the writeback |
| wb_data | output | 32 | Value written |
| illegal | output | 1 | Previous cycle held an undecodable valid instruction |

## Verification
The bench builds the slice with its default 32-bit data width. At this width the shift amount field is 6 bits wide. This brings two boundary cases within reach: amounts of exactly 32, where the result saturates, and amounts above 63, whose upper bits must be dropped. The default width also lets the sign-extension and upper-half immediate cases be checked against exact 32-bit constants. Instructions are issued back to back, so every result is consumed in the next cycle.

// File: rtl/ixs_pkg.sv
package ixs_pkg;

    localparam int IDX_W = 5;
    localparam int IMM_W = 16;

    localparam logic [5:0] PO_ADDI  = 6'd14;
    localparam logic [5:0] PO_ADDIS = 6'd15;
    localparam logic [5:0] PO_ORI   = 6'd24;
    localparam logic [5:0] PO_XFORM = 6'd31;

    localparam logic [9:0] XO_ADD  = 10'd266;
    localparam logic [9:0] XO_SUBF = 10'd40;
    localparam logic [9:0] XO_AND  = 10'd28;
    localparam logic [9:0] XO_OR   = 10'd444;
    localparam logic [9:0] XO_XOR  = 10'd316;
    localparam logic [9:0] XO_NAND = 10'd476;
    localparam logic [9:0] XO_SLW  = 10'd24;
    localparam logic [9:0] XO_SRW  = 10'd536;
    localparam logic [9:0] XO_SRAW = 10'd792;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUBF, ALU_AND, ALU_OR, ALU_XOR,
        ALU_NAND, ALU_SLW, ALU_SRW, ALU_SRAW
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_NONE, IMM_SEXT, IMM_HIGH, IMM_ZEXT
    } imm_kind_e;

    typedef struct packed {
        logic             legal;
        alu_op_e          op;
        imm_kind_e        imm_kind;
        logic             zero_a;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] ra;
        logic [IDX_W-1:0] rb;
        logic [IMM_W-1:0] imm;
    } dec_t;

    function automatic dec_t decode_word(logic [31:0] w);
        dec_t d;
        d.legal    = 1'b1;
        d.op       = ALU_ADD;
        d.imm_kind = IMM_NONE;
        d.zero_a   = 1'b0;
        d.rd       = w[25:21];
        d.ra       = w[20:16];
        d.rb       = w[15:11];
        d.imm      = w[15:0];
        case (w[31:26])
            PO_ADDI: begin
                d.imm_kind = IMM_SEXT;
                d.zero_a   = (w[20:16] == '0);
            end
            PO_ADDIS: begin
                d.imm_kind = IMM_HIGH;
                d.zero_a   = (w[20:16] == '0);
            end
            PO_ORI: begin
                d.imm_kind = IMM_ZEXT;
                d.op       = ALU_OR;
            end
            PO_XFORM: begin
                case (w[10:1])
                    XO_ADD:  d.op = ALU_ADD;
                    XO_SUBF: d.op = ALU_SUBF;
                    XO_AND:  d.op = ALU_AND;
                    XO_OR:   d.op = ALU_OR;
                    XO_XOR:  d.op = ALU_XOR;
                    XO_NAND: d.op = ALU_NAND;
                    XO_SLW:  d.op = ALU_SLW;
                    XO_SRW:  d.op = ALU_SRW;
                    XO_SRAW: d.op = ALU_SRAW;
                    default: d.legal = 1'b0;
                endcase
            end
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ixs_decode.sv
module ixs_decode
    import ixs_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);

    always_comb begin
        dec = decode_word(word);
    end

endmodule

// File: rtl/ixs_regfile.sv
module ixs_regfile #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [XLEN-1:0]  wdata,
    input  logic [IDX_W-1:0] raddr_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]  rdata_a,
    output logic [XLEN-1:0]  rdata_b
);

    localparam int NREGS = 1 << IDX_W;

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/ixs_alu.sv
module ixs_alu
    import ixs_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    localparam int SH_W = $clog2(XLEN) + 1;

    logic [SH_W-1:0] amt;
    logic            sat;

    assign amt = b[SH_W-1:0];
    assign sat = amt[SH_W-1];

    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUBF: y = b - a;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_NAND: y = ~(a & b);
            ALU_SLW:  y = sat ? '0 : (a << amt[SH_W-2:0]);
            ALU_SRW:  y = sat ? '0 : (a >> amt[SH_W-2:0]);
            ALU_SRAW: y = sat ? {XLEN{a[XLEN-1]}}
                              : XLEN'($signed(a) >>> amt[SH_W-2:0]);
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_slice.sv
module int_exec_slice
    import ixs_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_valid,
    input  logic [31:0]      insn,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]  wb_data,
    output logic             illegal
);

    dec_t            dec;
    logic [XLEN-1:0] rdata_a, rdata_b;
    logic [XLEN-1:0] opnd_a, opnd_b, imm_x, result;
    logic            commit;

    ixs_decode u_dec (
        .word (insn),
        .dec  (dec)
    );

    ixs_regfile #(.XLEN(XLEN), .IDX_W(IDX_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (commit),
        .waddr   (dec.rd),
        .wdata   (result),
        .raddr_a (dec.ra),
        .raddr_b (dec.rb),
        .rdata_a (rdata_a),
        .rdata_b (rdata_b)
    );

    always_comb begin
        case (dec.imm_kind)
            IMM_SEXT: imm_x = XLEN'($signed(dec.imm));
            IMM_HIGH: imm_x = XLEN'($signed({dec.imm, {IMM_W{1'b0}}}));
            IMM_ZEXT: imm_x = XLEN'(dec.imm);
            default:  imm_x = '0;
        endcase
    end

    assign opnd_a = dec.zero_a ? '0 : rdata_a;
    assign opnd_b = (dec.imm_kind == IMM_NONE) ? rdata_b : imm_x;
    assign commit = insn_valid && dec.legal;

    ixs_alu #(.XLEN(XLEN)) u_alu (
        .op (dec.op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_en   <= 1'b0;
            illegal <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            wb_en   <= commit;
            illegal <= insn_valid && !dec.legal;
            if (commit) begin
                wb_idx  <= dec.rd;
                wb_data <= result;
            end
        end
    end

endmodule

// File: rtl/ixs_checker.sv
module ixs_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            insn_valid,
    input logic [31:0]     insn,
    input logic            wb_en,
    input logic [4:0]      wb_idx,
    input logic [XLEN-1:0] wb_data,
    input logic            illegal
);

    logic known_po;
    assign known_po = (insn[31:26] == 6'd14) || (insn[31:26] == 6'd15) ||
                      (insn[31:26] == 6'd24) || (insn[31:26] == 6'd31);

    // R1
    dest_idx_chk: assert property (@(posedge clk) disable iff (rst)
        insn_valid && insn[31:26] == 6'd14 |=> wb_en && wb_idx == $past(insn[25:21]));

    // R2
    addi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        insn_valid && insn[31:26] == 6'd14 && insn[20:16] == 5'd0
        |=> wb_data == XLEN'($signed($past(insn[15:0]))));

    // R3
    addis_zero_chk: assert property (@(posedge clk) disable iff (rst)
        insn_valid && insn[31:26] == 6'd15 && insn[20:16] == 5'd0
        |=> wb_data == XLEN'($signed({$past(insn[15:0]), 16'h0000})));

    // R9
    bad_primary_chk: assert property (@(posedge clk) disable iff (rst)
        insn_valid && !known_po |=> illegal && !wb_en);

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> !illegal);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> !wb_en && !illegal);

endmodule

bind int_exec_slice ixs_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_int_exec_slice.sv
module sim_int_exec_slice;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 28;

    typedef struct packed {
        logic [31:0] insn;
        logic [31:0] exp;
        logic [4:0]  idx;
        logic        ill;
    } vec_t;

    function automatic logic [31:0] enc_d(logic [5:0] po, logic [4:0] d, logic [4:0] a,
                                          logic [15:0] imm);
        return {po, d, a, imm};
    endfunction

    function automatic logic [31:0] enc_x(logic [4:0] d, logic [4:0] a, logic [4:0] b,
                                          logic [9:0] xo);
        return {6'd31, d, a, b, xo, 1'b0};
    endfunction

    // R11: every vector consumes results written by the one before it
    localparam vec_t VEC [NV] = '{
        '{enc_d(6'd14, 5'd1, 5'd0, 16'd100),    32'h0000_0064, 5'd1,  1'b0}, // R2
        '{enc_d(6'd14, 5'd2, 5'd0, 16'hFFFE),   32'hFFFF_FFFE, 5'd2,  1'b0}, // R2
        '{enc_d(6'd15, 5'd3, 5'd0, 16'h2000),   32'h2000_0000, 5'd3,  1'b0}, // R3
        '{enc_d(6'd24, 5'd3, 5'd3, 16'h1000),   32'h2000_1000, 5'd3,  1'b0}, // R4
        '{enc_d(6'd14, 5'd4, 5'd1, 16'h8000),   32'hFFFF_8064, 5'd4,  1'b0}, // R2
        '{enc_d(6'd15, 5'd5, 5'd3, 16'h0001),   32'h2001_1000, 5'd5,  1'b0}, // R3
        '{enc_d(6'd14, 5'd0, 5'd0, 16'd5),      32'h0000_0005, 5'd0,  1'b0}, // R2
        '{enc_d(6'd24, 5'd6, 5'd0, 16'hF0F0),   32'h0000_F0F5, 5'd6,  1'b0}, // R4
        '{enc_d(6'd14, 5'd7, 5'd0, 16'd3),      32'h0000_0003, 5'd7,  1'b0}, // R2
        '{enc_x(5'd8,  5'd1, 5'd2, 10'd266),    32'h0000_0062, 5'd8,  1'b0}, // R5
        '{enc_x(5'd9,  5'd1, 5'd3, 10'd40),     32'h2000_0F9C, 5'd9,  1'b0}, // R6
        '{enc_x(5'd10, 5'd3, 5'd6, 10'd28),     32'h0000_1000, 5'd10, 1'b0}, // R5
        '{enc_x(5'd10, 5'd1, 5'd6, 10'd444),    32'h0000_F0F5, 5'd10, 1'b0}, // R5
        '{enc_x(5'd11, 5'd2, 5'd6, 10'd316),    32'hFFFF_0F0B, 5'd11, 1'b0}, // R5
        '{enc_x(5'd12, 5'd2, 5'd4, 10'd476),    32'h0000_7F9B, 5'd12, 1'b0}, // R5
        '{enc_x(5'd13, 5'd1, 5'd7, 10'd24),     32'h0000_0320, 5'd13, 1'b0}, // R7
        '{enc_x(5'd14, 5'd2, 5'd7, 10'd536),    32'h1FFF_FFFF, 5'd14, 1'b0}, // R7
        '{enc_x(5'd15, 5'd2, 5'd7, 10'd792),    32'hFFFF_FFFF, 5'd15, 1'b0}, // R8
        '{enc_d(6'd14, 5'd16, 5'd0, 16'd32),    32'h0000_0020, 5'd16, 1'b0}, // R2
        '{enc_x(5'd17, 5'd2, 5'd16, 10'd24),    32'h0000_0000, 5'd17, 1'b0}, // R7
        '{enc_x(5'd18, 5'd2, 5'd16, 10'd792),   32'hFFFF_FFFF, 5'd18, 1'b0}, // R8
        '{enc_x(5'd19, 5'd3, 5'd16, 10'd792),   32'h0000_0000, 5'd19, 1'b0}, // R8
        '{enc_d(6'd14, 5'd20, 5'd0, 16'h0041),  32'h0000_0041, 5'd20, 1'b0}, // R2
        '{enc_x(5'd21, 5'd2, 5'd20, 10'd536),   32'h7FFF_FFFF, 5'd21, 1'b0}, // R7
        '{enc_x(5'd22, 5'd4, 5'd7, 10'd792),    32'hFFFF_F00C, 5'd22, 1'b0}, // R8
        '{enc_d(6'd0, 5'd1, 5'd2, 16'h1234),    32'h0000_0000, 5'd0,  1'b1}, // R9
        '{enc_x(5'd1, 5'd2, 5'd3, 10'd1),       32'h0000_0000, 5'd0,  1'b1}, // R9
        '{enc_d(6'd24, 5'd23, 5'd1, 16'h0000),  32'h0000_0064, 5'd23, 1'b0}  // R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        illegal;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_exec_slice u0 (
        .clk        (clk),
        .rst        (rst),
        .insn_valid (insn_valid),
        .insn       (insn),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .illegal    (illegal)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_wb(input string tag, input logic [4:0] idx, input logic [31:0] val);
        check(wb_en && !illegal && wb_idx == idx && wb_data == val, tag,
              {wb_en, illegal, 25'd0, wb_idx, wb_data},
              {1'b1, 1'b0, 25'd0, idx, val});
    endtask

    task automatic issue(input logic [31:0] w);
        insn = w;
        insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(!wb_en && !illegal && wb_idx == 0 && wb_data == 0, "R10 reset outputs",
              {wb_en, illegal, 25'd0, wb_idx, wb_data}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            insn = VEC[i].insn;
            insn_valid = 1'b1;
            @(negedge clk);
            if (VEC[i].ill) begin
                check(illegal && !wb_en, $sformatf("R9 vector %0d", i),
                      {62'd0, illegal, wb_en}, 64'd2);
            end else begin
                expect_wb($sformatf("R1 vector %0d", i), VEC[i].idx, VEC[i].exp);
            end
        end
        insn_valid = 1'b0;

        // R10: an idle cycle carrying a writable word changes nothing
        insn = enc_d(6'd14, 5'd24, 5'd0, 16'd7);
        @(negedge clk);
        check(!wb_en && !illegal, "R10 idle no writeback", {62'd0, wb_en, illegal}, 64'd0);
        issue(enc_d(6'd24, 5'd25, 5'd24, 16'h0000));
        expect_wb("R10 idle left register", 5'd25, 32'h0);

        // R9: illegal flag lasts one cycle only
        issue(enc_d(6'd63, 5'd1, 5'd1, 16'hFFFF));
        check(illegal && !wb_en, "R9 flag raised", {62'd0, illegal, wb_en}, 64'd2);
        @(negedge clk);
        check(!illegal && !wb_en, "R9 flag one cycle", {62'd0, illegal, wb_en}, 64'd0);
        issue(enc_d(6'd24, 5'd26, 5'd1, 16'h0000));
        expect_wb("R9 destination untouched", 5'd26, 32'h64);

        // R3 + R4 + R11: two-instruction constant build
        issue(enc_d(6'd15, 5'd27, 5'd0, 16'hDEAD));
        expect_wb("R3 upper half", 5'd27, 32'hDEAD_0000);
        issue(enc_d(6'd24, 5'd27, 5'd27, 16'hBEEF));
        expect_wb("R11 constant build", 5'd27, 32'hDEAD_BEEF);

        // R10: reset clears the register file
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!wb_en && !illegal && wb_data == 0, "R10 mid-run reset",
              {wb_en, illegal, 30'd0, wb_data}, 64'd0);
        issue(enc_d(6'd24, 5'd28, 5'd1, 16'h0000));
        expect_wb("R10 registers cleared", 5'd28, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule